// File: doc/BRIEF.md
# Serial Memory SPI Target Front-End

This block is the serial target interface at the edge of a flash memory device. It takes the SPI pins and turns them into a stream of received bytes for a downstream command decoder, tagging the first byte of each transaction as the opcode. It also takes outbound bytes from that decoder and shifts them out on the serial output. It handles framing with the chip-select line, a dedicated active-low hardware reset pin, and the standby indication used by power management.

All pins are sampled by the system clock through a short synchronizer. Edges of the serial clock are detected in the system-clock domain, so the serial clock must run well below the system clock. The block accepts either clock idle level at selection, which covers SPI mode 0 and mode 3. Self-timed program and erase engines stay outside the block. They report their activity on a busy input, and that input holds off standby after deselection until the operation finishes.

Top module: `spi_target_fe`

## Requirements
- R1: A transaction starts only on a high-to-low transition of `spi_cs_n`. If chip select is already low when the hardware reset is released, nothing is accepted until chip select rises and falls again.
- R2: Input bits on `spi_si` are sampled on rising `spi_sck` edges, most significant bit first. After every 8 rising edges, `rx_valid` pulses for one cycle with the assembled byte on `rx_data`.
- R3: `rx_first` is 1 with the first byte of a transaction and 0 with every later byte of it.
- R4: The byte on `tx_data` is taken when a transaction starts, and its MSB is presented on `spi_so` before the first rising edge. Output bits advance MSB first on falling edges. The next byte is taken at the first falling edge after the 8th rising edge of a byte. `tx_req` pulses for one cycle each time a byte is taken.
- R5: Mode 0 (clock idle low) and mode 3 (clock idle high) both work. A falling edge before the first rising edge of a transaction neither shifts nor loads output data.
- R6: `spi_so_oe` is 0 and `spi_so` is 0 whenever the target is not in a transaction. Clock and data activity while deselected produces no received byte.
- R7: A rise of chip select discards a partial byte and resets the bit count. When the rise arrives in the same cycle as the 8th rising clock edge, the deselect wins and no byte is delivered.
- R8: While `hw_rst_n` is low, the transaction in progress is aborted. The output enable drops, no bytes are delivered, and the framing logic is held idle.
- R9: `spi_standby` is 1 one cycle after chip select is high and `op_busy` is 0, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Chip select pin, active low |
| spi_si | input | 1 | Serial data in pin |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the serial data out pad |
| rx_valid | output | 1 | One-cycle strobe: a byte was received |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Received byte is the first of its transaction |
| tx_data | input | 8 | Next outbound byte from the decoder |
| tx_req | output | 1 | One-cycle strobe: `tx_data` was taken |
| op_busy | input | 1 | A self-timed operation is running |
| spi_standby | output | 1 | Deselected and idle |

## Verification
Deselection and completion of a byte can land in the same system-clock cycle. The bench provokes this by raising chip select and the 8th serial clock edge at the same instant, so both pass through the synchronizer together. It then checks that no byte is delivered and that the next transaction starts aligned, with its opcode flag set. A hardware reset in mid-byte is also overlapped with continued clocking, and the bench expects silence until a fresh chip-select fall.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_SEL  = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
    } rx_beat_t;

    typedef struct packed {
        logic start;     // transaction accepted on chip-select fall
        logic sample;    // rising clock edge inside a transaction
        logic byte_end;  // sample that completes a byte
        logic shift;     // falling edge that advances the output byte
        logic load;      // falling edge that takes the next output byte
        logic first;     // current byte is the opcode byte
    } frame_ctl_t;

    function automatic edge_t edge_of(input logic now, input logic was);
        edge_t e;
        e.rise = now & ~was;
        e.fall = ~now & was;
        return e;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int unsigned       WIDTH   = 4,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
    import spi_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       hw_ok_s,
    output logic       active,
    output frame_ctl_t ctl
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    frame_state_e     state;
    logic             sck_q, cs_q;
    logic [CNT_W-1:0] cnt;
    logic             seen_rise, first_pend, load_pend;
    edge_t            sck_e, cs_e;
    logic             live;

    assign sck_e = edge_of(sck_s, sck_q);
    assign cs_e  = edge_of(cs_n_s, cs_q);
    assign live  = hw_ok_s & ~cs_n_s & (state == FS_SEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q      <= 1'b0;
            cs_q       <= 1'b1;
            state      <= FS_IDLE;
            cnt        <= '0;
            seen_rise  <= 1'b0;
            first_pend <= 1'b0;
            load_pend  <= 1'b0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
            if (!hw_ok_s || cs_n_s) begin
                state      <= FS_IDLE;
                cnt        <= '0;
                seen_rise  <= 1'b0;
                first_pend <= 1'b0;
                load_pend  <= 1'b0;
            end else if (state == FS_IDLE) begin
                if (cs_e.fall) begin
                    state      <= FS_SEL;
                    first_pend <= 1'b1;
                end
            end else begin
                if (sck_e.rise) begin
                    seen_rise <= 1'b1;
                    if (cnt == LAST) begin
                        cnt        <= '0;
                        load_pend  <= 1'b1;
                        first_pend <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (sck_e.fall && seen_rise && load_pend) begin
                    load_pend <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        ctl.start    = hw_ok_s & ~cs_n_s & (state == FS_IDLE) & cs_e.fall;
        ctl.sample   = live & sck_e.rise;
        ctl.byte_end = live & sck_e.rise & (cnt == LAST);
        ctl.shift    = live & sck_e.fall & seen_rise & ~load_pend;
        ctl.load     = live & sck_e.fall & seen_rise & load_pend;
        ctl.first    = first_pend;
    end

    assign active = (state == FS_SEL);

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
    import spi_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       si_s,
    input  frame_ctl_t ctl,
    output logic       valid,
    output rx_beat_t   beat
);

    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] next_sh;

    assign next_sh = {sh[BYTE_W-2:0], si_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            valid <= 1'b0;
            beat  <= '0;
        end else begin
            valid <= ctl.byte_end;
            if (ctl.start)       sh <= '0;
            else if (ctl.sample) sh <= next_sh;
            if (ctl.byte_end) begin
                beat.data  <= next_sh;
                beat.first <= ctl.first;
            end
        end
    end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_ctl_t        ctl,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              take,
    output logic              so_bit
);

    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            take <= 1'b0;
        end else begin
            take <= ctl.start | ctl.load;
            if (ctl.start || ctl.load) sh <= tx_byte;
            else if (ctl.shift)        sh <= {sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign so_bit = sh[BYTE_W-1];

endmodule

// File: rtl/spi_target_fe.sv
module spi_target_fe
    import spi_fe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    input  logic              hw_rst_n,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_first,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    input  logic              op_busy,
    output logic              spi_standby
);

    localparam int unsigned PIN_W = 4;

    logic       hw_ok_s, cs_n_s, sck_s, si_s;
    logic       active, so_bit;
    frame_ctl_t ctl;
    rx_beat_t   beat;

    spi_fe_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hw_rst_n, spi_cs_n, spi_sck, spi_si}),
        .q   ({hw_ok_s, cs_n_s, sck_s, si_s})
    );

    spi_fe_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sck_s   (sck_s),
        .cs_n_s  (cs_n_s),
        .hw_ok_s (hw_ok_s),
        .active  (active),
        .ctl     (ctl)
    );

    spi_fe_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .si_s  (si_s),
        .ctl   (ctl),
        .valid (rx_valid),
        .beat  (beat)
    );

    spi_fe_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .tx_byte (tx_data),
        .take    (tx_req),
        .so_bit  (so_bit)
    );

    assign rx_data   = beat.data;
    assign rx_first  = beat.first;
    assign spi_so_oe = active;
    assign spi_so    = active & so_bit;

    always_ff @(posedge clk) begin
        if (rst) spi_standby <= 1'b0;
        else     spi_standby <= cs_n_s & ~op_busy;
    end

endmodule

// File: rtl/spi_target_fe_chk.sv
module spi_target_fe_chk (
    input logic clk,
    input logic rst,
    input logic cs_n_s,
    input logic hw_ok_s,
    input logic op_busy,
    input logic spi_so_oe,
    input logic rx_valid,
    input logic tx_req,
    input logic spi_standby
);

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !spi_so_oe);

    p_rx_selected_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> spi_so_oe);

    p_hw_abort_r8: assert property (@(posedge clk) disable iff (rst)
        !hw_ok_s |=> (!spi_so_oe && !rx_valid));

    p_take_gap_r4: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);

    p_standby_on_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_n_s && !op_busy) |=> spi_standby);

    p_standby_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_s || op_busy) |=> !spi_standby);

endmodule

bind spi_target_fe spi_target_fe_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_s      (cs_n_s),
    .hw_ok_s     (hw_ok_s),
    .op_busy     (op_busy),
    .spi_so_oe   (spi_so_oe),
    .rx_valid    (rx_valid),
    .tx_req      (tx_req),
    .spi_standby (spi_standby)
);

// File: tb/spi_target_fe_tb.sv
module spi_target_fe_tb;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hw_rst_n = 1'b1, op_busy = 1'b0;
    logic so, so_oe, rx_valid, rx_first, tx_req, standby;
    logic [7:0] rx_data, tx_data;

    always #4 clk = ~clk;

    spi_target_fe u_dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .hw_rst_n(hw_rst_n), .spi_so(so), .spi_so_oe(so_oe),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
        .tx_data(tx_data), .tx_req(tx_req), .op_busy(op_busy),
        .spi_standby(standby)
    );

    int total = 0, fails = 0;
    int rx_cnt = 0, txr_cnt = 0;
    logic [7:0] log_d [0:511];
    logic       log_f [0:511];
    logic [7:0] tx_mem [0:15];
    logic [7:0] si_mem [0:15];
    logic [3:0] tx_idx = '0;
    logic       tx_clr = 1'b0;
    bit         done = 1'b0;

    assign tx_data = tx_mem[tx_idx];

    always @(negedge clk) begin
        if (rx_valid) begin
            log_d[rx_cnt % 512] <= rx_data;
            log_f[rx_cnt % 512] <= rx_first;
            rx_cnt <= rx_cnt + 1;
        end
        if (tx_req) txr_cnt <= txr_cnt + 1;
        if (tx_clr)      tx_idx <= '0;
        else if (tx_req) tx_idx <= tx_idx + 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        sck = 1'b0; si = b; wait_n(H);
        sck = 1'b1; wait_n(H);
    endtask

    task automatic run_xfer(input bit mode3, input int nb);
        int base, tbase;
        logic [7:0] got;
        tx_clr = 1'b1; wait_n(2); tx_clr = 1'b0;
        sck = mode3; wait_n(H);
        base = rx_cnt; tbase = txr_cnt;
        cs_n = 1'b0; wait_n(H);
        chk("R1 oe on select", so_oe, 1);
        for (int b = 0; b < nb; b++) begin
            got = '0;
            for (int i = 7; i >= 0; i--) begin
                sck = 1'b0; si = si_mem[b][i]; wait_n(H);
                got = {got[6:0], so};
                sck = 1'b1; wait_n(H);
            end
            chk(mode3 ? "R4 R5 so byte mode3" : "R4 so byte mode0", got, tx_mem[b]);
        end
        if (!mode3) begin sck = 1'b0; wait_n(H); end
        cs_n = 1'b1; wait_n(H);
        chk("R6 oe off after deselect", so_oe, 0);
        chk("R2 byte count", rx_cnt - base, nb);
        chk("R4 tx_req count", txr_cnt - tbase, mode3 ? nb : nb + 1);
        for (int b = 0; b < nb; b++) begin
            chk(mode3 ? "R2 R5 rx data mode3" : "R2 rx data mode0",
                log_d[(base + b) % 512], si_mem[b]);
            chk("R3 first flag", log_f[(base + b) % 512], (b == 0) ? 1 : 0);
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 16; i++) begin tx_mem[i] = 8'h00; si_mem[i] = 8'h00; end
        wait_n(4); rst = 1'b0; wait_n(6);

        chk("R6 reset oe", so_oe, 0);
        chk("R6 reset so", so, 0);
        chk("R2 reset rx_valid", rx_valid, 0);
        chk("R4 reset tx_req", tx_req, 0);
        chk("R9 reset standby", standby, 1);

        // R6: activity while deselected
        base = rx_cnt;
        for (int i = 0; i < 16; i++) clk_bit(1'($urandom_range(0, 1)));
        chk("R6 no rx while deselected", rx_cnt - base, 0);
        chk("R6 oe while deselected", so_oe, 0);
        sck = 1'b0; wait_n(H);

        // directed opcode patterns
        si_mem[0] = 8'h80; si_mem[1] = 8'h01; tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'hFF;
        run_xfer(1'b0, 2);
        si_mem[0] = 8'hFF; si_mem[1] = 8'h00; si_mem[2] = 8'h5A;
        tx_mem[0] = 8'h01; tx_mem[1] = 8'h80; tx_mem[2] = 8'hC3;
        run_xfer(1'b1, 3);

        // R7: partial byte then deselect
        base = rx_cnt;
        sck = 1'b0; cs_n = 1'b0; wait_n(H);
        for (int i = 0; i < 5; i++) clk_bit(1'b1);
        cs_n = 1'b1; wait_n(H);
        chk("R7 partial byte dropped", rx_cnt - base, 0);
        si_mem[0] = 8'h3B;
        run_xfer(1'b0, 1);

        // R7: deselect coincides with 8th rising edge
        base = rx_cnt;
        sck = 1'b0; wait_n(H); cs_n = 1'b0; wait_n(H);
        for (int i = 0; i < 7; i++) clk_bit(1'b0);
        sck = 1'b0; si = 1'b1; wait_n(H);
        sck = 1'b1; cs_n = 1'b1; wait_n(H);
        chk("R7 coincident deselect drops byte", rx_cnt - base, 0);
        chk("R7 oe after coincident deselect", so_oe, 0);
        si_mem[0] = 8'hC7; si_mem[1] = 8'h12;
        run_xfer(1'b1, 2);

        // R8 / R1: hardware reset mid-transaction
        base = rx_cnt;
        sck = 1'b0; wait_n(H); cs_n = 1'b0; wait_n(H);
        for (int i = 0; i < 12; i++) clk_bit(1'b1);
        hw_rst_n = 1'b0; wait_n(5);
        chk("R8 oe dropped in reset", so_oe, 0);
        for (int i = 0; i < 8; i++) clk_bit(1'b1);
        chk("R8 no rx in reset", rx_cnt - base, 1);
        hw_rst_n = 1'b1; wait_n(H);
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
        chk("R1 no rx without fresh select", rx_cnt - base, 1);
        chk("R1 oe stays off", so_oe, 0);
        sck = 1'b0; cs_n = 1'b1; wait_n(H);
        si_mem[0] = 8'h9E;
        run_xfer(1'b0, 1);

        // R9: standby and busy
        op_busy = 1'b1; wait_n(4);
        chk("R9 busy holds off standby", standby, 0);
        op_busy = 1'b0; wait_n(4);
        chk("R9 standby when idle", standby, 1);
        cs_n = 1'b0; wait_n(4);
        chk("R9 no standby while selected", standby, 0);
        cs_n = 1'b1; op_busy = 1'b1; wait_n(4);
        chk("R9 busy after deselect", standby, 0);
        op_busy = 1'b0; wait_n(4);
        chk("R9 standby after busy ends", standby, 1);

        // random transactions
        for (int t = 0; t < 20; t++) begin
            int nb;
            nb = $urandom_range(1, 4);
            for (int b = 0; b < 6; b++) begin
                si_mem[b] = 8'($urandom_range(0, 255));
                tx_mem[b] = 8'($urandom_range(0, 255));
            end
            run_xfer(1'($urandom_range(0, 1)), nb);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule